// File: doc/BRIEF.md
# CAN Bit Timing Resynchronizer

This block divides every bit on a CAN receive line into time quanta and places the sample point. A bit starts with a one-quantum sync segment. Next comes a first timing segment, made of a propagation part and a first phase part. A second phase part ends the bit. Each quantum is marked by a one-clock `tq_tick` pulse from an external prescaler. Three programmable fields set the segment lengths. A fourth field, the jump width, limits how far one correction may move the bit boundary.

The block watches the synchronized line for recessive-to-dominant transitions. A transition late in a bit, before the sample point, means the remote transmitter runs slow, so the first timing segment is stretched. A transition after the sample point means the transmitter runs fast, so the second phase segment is cut short. The correction equals the measured phase error, capped at the jump width. Only one such correction is made between two sample points. When `hard_sync_en` is held high, a falling transition restarts the bit at once and no cap applies. Frame logic uses this at start of frame.

The block drives three outputs. `sample_stb` marks the sample point, `sample_bit` holds the sampled level, and `bit_stb` marks the quantum that acts as the sync segment of a bit.

Top module: `can_bit_resync`

## Requirements
- R1: With no falling transition, a bit is 1 + (prop_len_m1+1) + (ph1_len_m1+1) + PS2 quanta long. `bit_stb` pulses for one clock after the tick that closes each sync quantum. After reset the first quantum is a sync quantum.
- R2: `sample_stb` pulses for one clock after the tick that closes the last quantum of the first timing segment. At that pulse `sample_bit` holds the line level seen at that tick. `sample_stb` and `bit_stb` never pulse together, and never except after a tick.
- R3: A falling transition in quantum k (k ≥ 1) of the first timing segment, counting from 1, is a late edge with phase error k. When k ≤ jump width, the segment is stretched by k, so that a full first timing segment follows the edge quantum.
- R4: For a late edge, the stretch is never larger than the jump width.
- R5: A falling transition in the second phase segment is an early edge. Its phase error is the number of quanta left in that segment, counting the edge quantum. When this error is ≤ jump width, the edge quantum becomes the sync quantum of a new bit and `bit_stb` pulses.
- R6: For an early edge whose error exceeds the jump width, the second phase segment is shortened by exactly the jump width.
- R7: A falling transition inside the sync quantum moves nothing.
- R8: After one correction, further falling transitions cause no correction until the next sample point.
- R9: Rising transitions never move the bit timing.
- R10: While `hard_sync_en` is high, a falling transition in any quantum makes that quantum the sync quantum of a new bit. This holds whatever the phase error, the jump width or an earlier correction. `bit_stb` pulses.
- R11: PS2 = max(ph2_len_m1+1, 2). The effective jump width = min(sjw_m1+1, PS2).
- R12: During and right after synchronous reset, both strobes are low and `sample_bit` is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tq_tick | input | 1 | One-clock pulse that ends each time quantum |
| rx_in | input | 1 | Synchronized receive line, 1 = recessive |
| hard_sync_en | input | 1 | While high, falling edges restart the bit without limit |
| prop_len_m1 | input | 3 | Propagation segment length minus one |
| ph1_len_m1 | input | 3 | Phase segment 1 length minus one |
| ph2_len_m1 | input | 3 | Phase segment 2 length minus one (floored to 2 quanta) |
| sjw_m1 | input | 2 | Jump width minus one |
| sample_stb | output | 1 | Sample point strobe |
| sample_bit | output | 1 | Line level taken at the last sample point |
| bit_stb | output | 1 | Strobe for the quantum acting as sync segment |

## Verification
A wrong quantum position or a wrong stored segment length shows at the ports within one bit. The next `sample_stb` or `bit_stb` lands on a different tick than the one computed from the programmed lengths. Scenarios therefore place a single falling edge in a chosen quantum and compare the tick index of every later strobe. A stuck or missed "already corrected" flag shows up on the first edge that follows in the same bit: the sample point after it moves. A broken clamp on jump width or phase segment 2 shows as a sample point shifted by the difference.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    localparam int SEG_FW  = 3;
    localparam int SJW_FW  = 2;
    localparam int SEG_MAX = 1 << SEG_FW;
    localparam int SJW_MAX = 1 << SJW_FW;
    localparam int PS2_MIN = 2;
    // first timing segment can hold two full fields plus one stretch
    localparam int CNT_W   = $clog2(2 * SEG_MAX + SJW_MAX + 1);

    typedef logic [SEG_FW-1:0] seg_fld_t;
    typedef logic [SJW_FW-1:0] sjw_fld_t;
    typedef logic [CNT_W-1:0]  qcnt_t;

    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,
        PH_TS1  = 2'd1,
        PH_TS2  = 2'd2
    } phase_e;

    typedef struct packed {
        qcnt_t ts1_len;
        qcnt_t ps2_len;
        qcnt_t jump;
    } bt_cfg_t;

    typedef struct packed {
        phase_e ph;
        qcnt_t  pos;
        qcnt_t  ts1_len;
        qcnt_t  ps2_len;
        logic   locked;
    } bt_state_t;

    function automatic qcnt_t fld_len(input seg_fld_t f);
        return qcnt_t'(f) + qcnt_t'(1);
    endfunction

    function automatic qcnt_t qmin(input qcnt_t a, input qcnt_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic qcnt_t qmax(input qcnt_t a, input qcnt_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg
    import can_bt_pkg::*;
(
    input  seg_fld_t prop_f,
    input  seg_fld_t ph1_f,
    input  seg_fld_t ph2_f,
    input  sjw_fld_t sjw_f,
    output bt_cfg_t  cfg
);

    qcnt_t ps2_raw;
    qcnt_t jump_raw;

    always_comb begin
        cfg.ts1_len = fld_len(prop_f) + fld_len(ph1_f);
        ps2_raw     = fld_len(ph2_f);
        cfg.ps2_len = qmax(ps2_raw, qcnt_t'(PS2_MIN));
        jump_raw    = qcnt_t'(sjw_f) + qcnt_t'(1);
        // R11: jump width never exceeds the second phase segment
        cfg.jump    = qmin(jump_raw, cfg.ps2_len);
    end

endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rx,
    output logic fall
);

    logic rx_q;

    always_ff @(posedge clk) begin
        if (rst)
            rx_q <= 1'b1;
        else if (tick)
            rx_q <= rx;
    end

    // R9: only a high-to-low change between two quantum ends counts
    assign fall = tick && rx_q && !rx;

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
    import can_bt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    rx,
    input  logic    fall,
    input  logic    hard_sync,
    input  bt_cfg_t cfg,
    output logic    sample_stb,
    output logic    sample_bit,
    output logic    bit_stb
);

    bt_state_t st;
    bt_state_t nx;
    logic      nx_smp;
    logic      nx_bit;
    logic      as_sync;
    logic      resync_ok;
    qcnt_t     pos_inc;
    qcnt_t     err_early;
    qcnt_t     grow;

    always_comb begin
        nx        = st;
        nx_smp    = 1'b0;
        nx_bit    = 1'b0;
        as_sync   = 1'b0;
        pos_inc   = st.pos + qcnt_t'(1);
        err_early = st.ps2_len - st.pos;
        grow      = qmin(pos_inc, cfg.jump);
        resync_ok = fall && !st.locked;
        if (tick) begin
            if (st.ph == PH_SYNC || (fall && hard_sync)) begin
                as_sync = 1'b1;
            end else if (st.ph == PH_TS1) begin
                nx.pos = pos_inc;
                if (resync_ok) begin
                    // late edge: stretch by phase error, capped
                    nx.ts1_len = st.ts1_len + grow;
                    nx.locked  = 1'b1;
                end else if (pos_inc == st.ts1_len) begin
                    nx_smp    = 1'b1;
                    nx.ph     = PH_TS2;
                    nx.pos    = '0;
                    nx.locked = 1'b0;
                end
            end else begin
                if (resync_ok && err_early <= cfg.jump) begin
                    as_sync = 1'b1;
                end else begin
                    if (resync_ok) begin
                        // early edge beyond reach: cut by the jump width
                        nx.ps2_len = st.ps2_len - cfg.jump;
                        nx.locked  = 1'b1;
                    end
                    nx.pos = pos_inc;
                    if (pos_inc >= nx.ps2_len) begin
                        nx.ph  = PH_SYNC;
                        nx.pos = '0;
                    end
                end
            end
            if (as_sync) begin
                nx.ph      = PH_TS1;
                nx.pos     = '0;
                nx.ts1_len = cfg.ts1_len;
                nx.ps2_len = cfg.ps2_len;
                nx.locked  = st.locked | (fall && (hard_sync || st.ph == PH_TS2));
                nx_bit     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= '{ph: PH_SYNC, pos: '0, ts1_len: '0, ps2_len: '0, locked: 1'b0};
            sample_stb <= 1'b0;
            bit_stb    <= 1'b0;
            sample_bit <= 1'b1;
        end else begin
            st         <= nx;
            sample_stb <= nx_smp;
            bit_stb    <= nx_bit;
            if (nx_smp)
                sample_bit <= rx;
        end
    end

    a_r2_strobe_after_tick: assert property (@(posedge clk) disable iff (rst)
        (sample_stb || bit_stb) |-> $past(tick));

    a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(sample_stb && bit_stb));

    a_r4_ts1_pos_bound: assert property (@(posedge clk) disable iff (rst)
        (st.ph == PH_TS1) |-> (st.pos < st.ts1_len));

    a_r4_stretch_capped: assert property (@(posedge clk) disable iff (rst)
        (st.ph == PH_TS1) |-> (st.ts1_len <= cfg.ts1_len + cfg.jump));

    a_r6_ts2_pos_bound: assert property (@(posedge clk) disable iff (rst)
        (st.ph == PH_TS2) |-> (st.pos < st.ps2_len));

    a_r7_sync_no_shift: assert property (@(posedge clk) disable iff (rst)
        (tick && st.ph == PH_SYNC) |=> (st.ph == PH_TS1 && st.ts1_len == $past(cfg.ts1_len)));

    a_r8_single_resync: assert property (@(posedge clk) disable iff (rst)
        (tick && fall && st.locked && !hard_sync && st.ph == PH_TS1)
        |=> (st.ts1_len == $past(st.ts1_len)));

    a_r10_hard_restart: assert property (@(posedge clk) disable iff (rst)
        (tick && fall && hard_sync) |=> (bit_stb && st.ph == PH_TS1 && st.pos == '0));

endmodule

// File: rtl/can_bit_resync.sv
module can_bit_resync
    import can_bt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tq_tick,
    input  logic                rx_in,
    input  logic                hard_sync_en,
    input  logic [SEG_FW-1:0]   prop_len_m1,
    input  logic [SEG_FW-1:0]   ph1_len_m1,
    input  logic [SEG_FW-1:0]   ph2_len_m1,
    input  logic [SJW_FW-1:0]   sjw_m1,
    output logic                sample_stb,
    output logic                sample_bit,
    output logic                bit_stb
);

    bt_cfg_t cfg;
    logic    fall;

    can_bt_cfg u_cfg (
        .prop_f (prop_len_m1),
        .ph1_f  (ph1_len_m1),
        .ph2_f  (ph2_len_m1),
        .sjw_f  (sjw_m1),
        .cfg    (cfg)
    );

    can_bt_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .tick (tq_tick),
        .rx   (rx_in),
        .fall (fall)
    );

    can_bt_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tq_tick),
        .rx         (rx_in),
        .fall       (fall),
        .hard_sync  (hard_sync_en),
        .cfg        (cfg),
        .sample_stb (sample_stb),
        .sample_bit (sample_bit),
        .bit_stb    (bit_stb)
    );

endmodule

// File: tb/sim_can_bit_resync.sv
module sim_can_bit_resync;
    import can_bt_pkg::*;

    logic     clk = 1'b0;
    logic     rst = 1'b1;
    logic     tq_tick = 1'b0;
    logic     rx_in = 1'b1;
    logic     hard_sync_en = 1'b0;
    seg_fld_t prop_f = '0;
    seg_fld_t ph1_f = '0;
    seg_fld_t ph2_f = '0;
    sjw_fld_t sjw_f = '0;
    logic     sample_stb;
    logic     sample_bit;
    logic     bit_stb;

    int total = 0;
    int bad = 0;
    int cur_q = 0;

    typedef struct {
        int    q;
        bit    smp;
        bit    val;
        string tag;
    } ev_t;

    ev_t exp_q[$];

    always #10 clk = ~clk;

    can_bit_resync u0 (
        .clk          (clk),
        .rst          (rst),
        .tq_tick      (tq_tick),
        .rx_in        (rx_in),
        .hard_sync_en (hard_sync_en),
        .prop_len_m1  (prop_f),
        .ph1_len_m1   (ph1_f),
        .ph2_len_m1   (ph2_f),
        .sjw_m1       (sjw_f),
        .sample_stb   (sample_stb),
        .sample_bit   (sample_bit),
        .bit_stb      (bit_stb)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic void push(input int q, input bit smp, input bit val, input string tag);
        ev_t e;
        e.q = q; e.smp = smp; e.val = val; e.tag = tag;
        exp_q.push_back(e);
    endfunction

    task automatic pop_cmp(input bit smp, input bit val);
        ev_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R1", "unexpected strobe at quantum", cur_q, -1);
        end else begin
            e = exp_q.pop_front();
            check(e.smp == smp, e.tag, "strobe kind (1=sample)", int'(smp), int'(e.smp));
            check(e.q == cur_q, e.tag, "strobe quantum", cur_q, e.q);
            if (smp && e.smp)
                check(e.val == val, e.tag, "sampled bit", int'(val), int'(e.val));
        end
    endtask

    // monitor: outputs settle after the posedge, read them at the negedge
    always @(negedge clk) begin
        if (!rst) begin
            if (bit_stb)    pop_cmp(1'b0, 1'b0);
            if (sample_stb) pop_cmp(1'b1, sample_bit);
        end
    end

    function automatic logic [63:0] lo(input int a, input int b);
        logic [63:0] v = '1;
        for (int i = a; i < b; i++) v[i] = 1'b0;
        return v;
    endfunction

    // pat[n] = line level during quantum n (n counted from 1 after reset)
    task automatic run_case(input string tag, input int pf, input int af, input int bf,
                            input int jf, input logic [63:0] pat, input logic hs, input int nq);
        @(negedge clk);
        rst = 1'b1; tq_tick = 1'b0; rx_in = 1'b1; hard_sync_en = 1'b0;
        prop_f = seg_fld_t'(pf); ph1_f = seg_fld_t'(af);
        ph2_f = seg_fld_t'(bf); sjw_f = sjw_fld_t'(jf);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        check(sample_stb == 1'b0, "R12", "sample_stb after reset", int'(sample_stb), 0);
        check(bit_stb == 1'b0, "R12", "bit_stb after reset", int'(bit_stb), 0);
        check(sample_bit == 1'b1, "R12", "sample_bit after reset", int'(sample_bit), 1);
        hard_sync_en = hs;
        for (int n = 1; n <= nq; n++) begin
            @(negedge clk);
            tq_tick = 1'b0;
            rx_in = pat[n];
            @(negedge clk);
            @(negedge clk);
            tq_tick = 1'b1;
            cur_q = n;
        end
        @(negedge clk);
        tq_tick = 1'b0;
        @(negedge clk);
        check(exp_q.size() == 0, tag, "events still expected", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        // R1/R2 nominal bit of 1+2+3+3 quanta, line recessive
        push(1, 0, 0, "R1");  push(6, 1, 1, "R2");
        push(10, 0, 0, "R1"); push(15, 1, 1, "R2");
        push(19, 0, 0, "R1"); push(24, 1, 1, "R2");
        push(28, 0, 0, "R1"); push(33, 1, 1, "R2");
        run_case("R1", 1, 2, 2, 1, '1, 1'b0, 34);

        // R2 earliest sample point: 1+1 quanta then 8 quanta of phase 2
        push(1, 0, 0, "R1");  push(3, 1, 1, "R2");
        push(12, 0, 0, "R1"); push(14, 1, 1, "R2");
        run_case("R2", 0, 0, 7, 1, '1, 1'b0, 15);

        // R3 late edge error 2 within jump width 2
        push(1, 0, 0, "R1");  push(8, 1, 0, "R3");
        push(12, 0, 0, "R3"); push(17, 1, 0, "R3");
        run_case("R3", 1, 2, 2, 1, lo(3, 64), 1'b0, 18);

        // R4 late edge error 4, stretch capped at 1
        push(1, 0, 0, "R1");  push(7, 1, 0, "R4");
        push(11, 0, 0, "R4"); push(16, 1, 0, "R4");
        run_case("R4", 1, 2, 2, 0, lo(5, 64), 1'b0, 17);

        // R5 early edge error 2 within jump width 2
        push(1, 0, 0, "R1");  push(6, 1, 1, "R2");
        push(8, 0, 0, "R5");  push(13, 1, 0, "R5");
        push(17, 0, 0, "R5");
        run_case("R5", 1, 2, 2, 1, lo(8, 64), 1'b0, 18);

        // R6 early edge error 3, shortened by 1 only
        push(1, 0, 0, "R1");  push(6, 1, 1, "R2");
        push(9, 0, 0, "R6");  push(14, 1, 0, "R6");
        push(18, 0, 0, "R6");
        run_case("R6", 1, 2, 2, 0, lo(7, 64), 1'b0, 19);

        // R7 edge inside sync quantum of the second bit
        push(1, 0, 0, "R1");  push(6, 1, 1, "R2");
        push(10, 0, 0, "R7"); push(15, 1, 0, "R7");
        push(19, 0, 0, "R7"); push(24, 1, 0, "R7");
        run_case("R7", 1, 2, 2, 1, lo(10, 64), 1'b0, 25);

        // R8 second edge before the sample point is ignored
        push(1, 0, 0, "R1");  push(8, 1, 0, "R8");
        push(12, 0, 0, "R8"); push(17, 1, 0, "R8");
        run_case("R8", 1, 2, 2, 1, lo(3, 5) & lo(6, 64), 1'b0, 18);

        // R9 rising edge inside the first timing segment is ignored
        push(1, 0, 0, "R1");  push(6, 1, 1, "R9");
        push(10, 0, 0, "R9");
        run_case("R9", 1, 2, 2, 1, lo(1, 4), 1'b0, 11);

        // R10 hard sync in segment 1 and in segment 2 beyond jump width
        push(1, 0, 0, "R1");   push(4, 0, 0, "R10");
        push(9, 1, 1, "R10");  push(10, 0, 0, "R10");
        push(15, 1, 0, "R10"); push(19, 0, 0, "R10");
        run_case("R10", 1, 2, 2, 0, lo(4, 6) & lo(10, 64), 1'b1, 20);

        // R11 phase 2 floored to 2, jump width 4 clamped to 2
        push(1, 0, 0, "R1");   push(8, 1, 0, "R11");
        push(11, 0, 0, "R11"); push(16, 1, 0, "R11");
        run_case("R11", 1, 2, 0, 3, lo(5, 64), 1'b0, 17);

        finish_run();
    end

endmodule